// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the frame strobe of a serial audio link when the link runs as clock master. It does not generate the bit clock itself. It takes a one-cycle bit tick that marks each bit-clock period and counts bits against a programmed channel bit count. It supports two frame formats:

- **Word-clock format.** The strobe is a 50% left/right word clock. The count covers one channel, so a frame is two channels long.
- **Pulse format.** The strobe is a short pulse of programmable width once per frame. This format serves DSP-style and TDM framing, and the count covers the whole frame.

For the data shifter, the block reports the start of each frame and the index of the current bit within the frame. The active strobe level comes from a polarity input. A frame-invert input flips that level, so the usual conventions can all be set: I2S uses a low first channel, and justified or DSP modes use a high one.

Top module: `afs_frame_gen`

## Requirements
- R1: After reset, with `enable` low, `frame_strobe` sits at the inactive level, `frame_start` is 0 and `bit_index` is 0.
- R2: The first `bit_tick` seen with `enable` high starts a frame. From the following clock, `frame_start` is 1 and `bit_index` is 0.
- R3: With `fmt_sel`=0 (word-clock format), a frame is 2*(`bit_count`+1) ticks long. The strobe is at the active level for the first `bit_count`+1 ticks and at the inactive level for the rest. `frame_start` marks the return to the first channel.
- R4: With `fmt_sel`=1 (pulse format), a frame is `bit_count`+1 ticks long, and `frame_start` recurs at the start of every frame.
- R5: In pulse format the strobe is active for `pulse_width`+1 ticks starting at frame start, so 0 gives one tick and 255 gives 256 ticks. The pulse is clipped at the frame end.
- R6: `pulse_width` has no effect in word-clock format.
- R7: The active strobe level is `pol_high` XOR `frame_inv`, where 1 means high. While the block is idle the strobe sits at the opposite level.
- R8: Position advances only on clocks with `bit_tick`=1. Outputs hold between ticks.
- R9: Dropping `enable` returns the block to idle on the next clock, whatever the position in the frame. The next enable restarts from bit 0.
- R10: `bit_index` counts 0, 1, … up to frame length − 1 and then wraps to 0. The frame length is the one given by R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle marker of each bit-clock period |
| enable | input | 1 | Run request; low forces idle |
| fmt_sel | input | 1 | 0 = word-clock format, 1 = pulse format |
| bit_count | input | CNT_W (9) | Channel bit count minus one (word-clock) or frame bits minus one (pulse) |
| pulse_width | input | PW_W (8) | Pulse length minus one, in ticks |
| pol_high | input | 1 | 1 = active level high |
| frame_inv | input | 1 | Inverts the active level |
| frame_strobe | output | 1 | Word clock or frame pulse |
| frame_start | output | 1 | High during the first bit of each frame |
| bit_index | output | CNT_W+1 (10) | Bit position within the frame |

## Verification
A counter that wraps one tick early or late shows at once at the ports. `bit_index` jumps to the wrong value and `frame_start` shifts, both on the very clock that follows the faulty tick. A channel flag that fails to toggle leaves the word clock stuck at one level. That is visible within `bit_count`+1 ticks, and `bit_index` drops back to 0 where it should continue upward. A wrong pulse-width comparison changes the strobe on the tick at position `pulse_width`+1. The bench compares all three outputs on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef enum logic {
    FMT_WORDCLK = 1'b0,
    FMT_PULSE   = 1'b1
  } afs_fmt_e;
endpackage

// File: rtl/afs_rst_sync.sv
module afs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/afs_bit_counter.sv
module afs_bit_counter
  import afs_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             enable,
  input  afs_fmt_e         fmt,
  input  logic [CNT_W-1:0] bit_count,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             half
);
  logic             run_d, half_d;
  logic [CNT_W-1:0] cnt_d;

  // next-state
  always_comb begin
    run_d  = run;
    cnt_d  = cnt;
    half_d = half;
    if (!enable) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (bit_tick) begin
      if (!run) begin
        run_d  = 1'b1;
        cnt_d  = '0;
        half_d = 1'b0;
      end else if (cnt >= bit_count) begin
        cnt_d  = '0;
        half_d = (fmt == FMT_PULSE) ? 1'b0 : ~half;
      end else begin
        cnt_d = cnt + 1'b1;
        if (fmt == FMT_PULSE) half_d = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      run  <= run_d;
      cnt  <= cnt_d;
      half <= half_d;
    end
  end

  // R8: position only moves on a tick
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bit_tick) |=> ($stable(cnt) && $stable(half)));

  // R3: channel flag flips at each channel boundary in word-clock format
  p_half_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bit_tick && run && fmt == FMT_WORDCLK && cnt >= bit_count)
      |=> (half != $past(half)));

  // R4: pulse format never enters the second half
  p_pulse_no_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bit_tick && fmt == FMT_PULSE) |=> !half);
endmodule

// File: rtl/afs_strobe_shaper.sv
module afs_strobe_shaper
  import afs_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int PW_W  = 8
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             half,
  input  afs_fmt_e         fmt,
  input  logic [CNT_W-1:0] bit_count,
  input  logic [PW_W-1:0]  pulse_width,
  input  logic             act_lvl,
  output logic             strobe,
  output logic             start,
  output logic [CNT_W:0]   idx
);
  localparam int CMP_W = (CNT_W > PW_W) ? CNT_W : PW_W;

  logic in_pulse;
  logic [CNT_W:0] half_len;

  assign in_pulse = (CMP_W'(cnt) <= CMP_W'(pulse_width));
  assign half_len = {1'b0, bit_count} + 1'b1;

  always_comb begin
    if (!run) begin
      strobe = ~act_lvl;
      start  = 1'b0;
      idx    = '0;
    end else begin
      start = (cnt == '0) && !half;
      idx   = {1'b0, cnt} + (half ? half_len : '0);
      if (fmt == FMT_PULSE) strobe = in_pulse ? act_lvl : ~act_lvl;
      else                  strobe = half ? ~act_lvl : act_lvl;
    end
  end
endmodule

// File: rtl/afs_frame_gen.sv
module afs_frame_gen
  import afs_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int PW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             enable,
  input  logic             fmt_sel,
  input  logic [CNT_W-1:0] bit_count,
  input  logic [PW_W-1:0]  pulse_width,
  input  logic             pol_high,
  input  logic             frame_inv,
  output logic             frame_strobe,
  output logic             frame_start,
  output logic [CNT_W:0]   bit_index
);
  logic             rst_sync_n;
  logic             run, half, act_lvl;
  logic [CNT_W-1:0] cnt;
  afs_fmt_e         fmt;

  assign fmt     = afs_fmt_e'(fmt_sel);
  assign act_lvl = pol_high ^ frame_inv;

  afs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  afs_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .bit_tick(bit_tick), .enable(enable),
    .fmt(fmt), .bit_count(bit_count), .run(run), .cnt(cnt), .half(half)
  );

  afs_strobe_shaper #(.CNT_W(CNT_W), .PW_W(PW_W)) u_shape (
    .run(run), .cnt(cnt), .half(half), .fmt(fmt), .bit_count(bit_count),
    .pulse_width(pulse_width), .act_lvl(act_lvl),
    .strobe(frame_strobe), .start(frame_start), .idx(bit_index)
  );

  // R2: first tick under enable opens a frame
  p_start_on_enable_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && bit_tick && !run) |=> (frame_start && bit_index == '0));

  // R9: disable returns to idle on the next clock
  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable |=> (!frame_start && bit_index == '0));

  // R5: the pulse is active on the first bit of every pulse-format frame
  p_pulse_at_start_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start && fmt_sel) |-> (frame_strobe == act_lvl));

  // R3: word-clock frame begins in the first (active) channel
  p_wordclk_start_lvl_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start && !fmt_sel) |-> (frame_strobe == act_lvl));
endmodule

// File: tb/afs_frame_gen_tb_top.sv
module afs_frame_gen_tb_top;
  localparam int CNT_W = 9;
  localparam int PW_W  = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bit_tick, enable, fmt_sel, pol_high, frame_inv;
  logic [CNT_W-1:0] bit_count;
  logic [PW_W-1:0]  pulse_width;
  logic             frame_strobe, frame_start;
  logic [CNT_W:0]   bit_index;

  always #2.5 clk = ~clk;

  afs_frame_gen #(.CNT_W(CNT_W), .PW_W(PW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .enable(enable),
    .fmt_sel(fmt_sel), .bit_count(bit_count), .pulse_width(pulse_width),
    .pol_high(pol_high), .frame_inv(frame_inv),
    .frame_strobe(frame_strobe), .frame_start(frame_start), .bit_index(bit_index)
  );

  typedef struct {
    logic       strobe;
    logic       start;
    int         idx;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  bit   m_run   = 0;
  int   m_k     = 0;

  task automatic check(input string req, input string what, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pop and compare one expected item per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "frame_strobe", int'(frame_strobe), int'(e.strobe));
        check(e.req, "frame_start",  int'(frame_start),  int'(e.start));
        check(e.req, "bit_index",    int'(bit_index),    e.idx);
      end
    end
  end

  // driver: one clock, with reference model of the frame position
  task automatic step(input logic tk, input string req);
    exp_t e;
    int   len;
    logic act;
    @(negedge clk);
    bit_tick = tk;
    len = fmt_sel ? (int'(bit_count) + 1) : 2 * (int'(bit_count) + 1);
    if (!enable) begin
      m_run = 0; m_k = 0;
    end else if (tk) begin
      if (!m_run) begin
        m_run = 1; m_k = 0;
      end else begin
        m_k = m_k + 1;
        if (m_k >= len) m_k = 0;
      end
    end
    act = pol_high ^ frame_inv;
    e.req = req;
    if (!m_run) begin
      e.strobe = ~act; e.start = 1'b0; e.idx = 0;
    end else begin
      e.start = (m_k == 0);
      e.idx   = m_k;
      if (fmt_sel) e.strobe = (m_k <= int'(pulse_width)) ? act : ~act;
      else         e.strobe = (m_k < int'(bit_count) + 1) ? act : ~act;
    end
    q.push_back(e);
    @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1, req);
      for (int g = 0; g < gap; g++) step(1'b0, req);
    end
  endtask

  task automatic restart(input string req);
    enable = 1'b0;
    step(1'b0, "R9");
    enable = 1'b1;
    step(1'b1, "R2");
    ticks(1, 0, req);
  endtask

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; enable = 1'b0; fmt_sel = 1'b0;
    bit_count = 9'd3; pulse_width = 8'd0; pol_high = 1'b0; frame_inv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state: inactive level is high for pol_high=0
    check("R1", "frame_strobe", int'(frame_strobe), 1);
    check("R1", "frame_start",  int'(frame_start),  0);
    check("R1", "bit_index",    int'(bit_index),    0);
    #1;

    // R3 word-clock, 4 bits per channel, I2S-style low first channel
    restart("R3");
    ticks(20, 0, "R3");
    // R8 sparse ticks
    ticks(12, 2, "R8");
    // R9 mid-frame drop and restart
    restart("R9");
    ticks(5, 1, "R9");
    // R6 pulse width must not disturb word clock
    enable = 1'b0; step(1'b0, "R9");
    pulse_width = 8'd200;
    restart("R6");
    ticks(18, 0, "R6");
    // R10 shortest word-clock frame
    enable = 1'b0; step(1'b0, "R9");
    bit_count = 9'd0;
    restart("R10");
    ticks(8, 0, "R10");
    // R4 pulse format, 8-bit frame, one-tick pulse, active high
    enable = 1'b0; step(1'b0, "R9");
    fmt_sel = 1'b1; bit_count = 9'd7; pulse_width = 8'd0; pol_high = 1'b1;
    restart("R4");
    ticks(24, 0, "R4");
    // R5 three-tick pulse with gapped ticks
    enable = 1'b0; step(1'b0, "R9");
    pulse_width = 8'd2;
    restart("R5");
    ticks(20, 2, "R5");
    // R7 inverted pulse
    enable = 1'b0; step(1'b0, "R9");
    frame_inv = 1'b1;
    restart("R7");
    ticks(16, 0, "R7");
    // R7 inverted word clock with high base polarity
    enable = 1'b0; step(1'b0, "R9");
    fmt_sel = 1'b0; bit_count = 9'd5;
    restart("R7");
    ticks(26, 0, "R7");
    // R5 widest pulse, 256 ticks in a 301-bit frame
    enable = 1'b0; step(1'b0, "R9");
    fmt_sel = 1'b1; frame_inv = 1'b0; bit_count = 9'd300; pulse_width = 8'd255;
    restart("R5");
    ticks(320, 0, "R5");
    // R10 index up to 2*(bc+1)-1 with the largest word-clock count used here
    enable = 1'b0; step(1'b0, "R9");
    fmt_sel = 1'b0; bit_count = 9'd300;
    restart("R10");
    ticks(610, 0, "R10");
    enable = 1'b0; step(1'b0, "R9");
    step(1'b0, "R9");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule